// File: doc/BRIEF.md
# Dual-Bank Multiport Data Register File

This block is the working register store of a numeric datapath. It keeps two banks of sixteen 40-bit words, a primary bank and an alternate bank. A single select input chooses which bank every port uses, so a routine can take over a complete fresh register set without saving the old one.

Six read ports and five write ports operate in parallel every cycle. Two reads feed an ALU and two feed a multiplier. Result writes come from the multiplier, the ALU, and a second ALU result that is used only by a combined add/subtract. Two external-memory ports each read one register and can also write it. Every write port has a fixed-point flag; when it is set, the low byte of the stored word is cleared, so a 32-bit fixed-point value sits in the top of the word. Read data is registered, and a write is visible to every port from the next cycle on.

Top module: `rf_dual_bank`

## Requirements
- R1: Each read port returns, one rising edge after its address is presented, the 40-bit word held at that address (0 to 15) in the active bank.
- R2: The bank select input is sampled at a rising edge: 0 selects the primary bank and 1 the alternate bank, for accesses in the following cycle and later. During a cycle that uses one bank, no word of the other bank changes.
- R3: The same address in the two banks holds two independent words.
- R4: A word written at a rising edge is returned by any read port whose address is presented in a later cycle. A read presented in the same cycle as a write to its address returns the previous contents.
- R5: When several write ports target the same register in one cycle, exactly one write is stored. The order of precedence is external port 0, then external port 1, then the multiplier port, then the ALU port, then the second ALU port.
- R6: The second ALU write port stores only while its enable (the dual-result add/subtract strobe) is high. Otherwise its address and data have no effect.
- R7: A write with its fixed-point flag set stores write data bits 39..8 unchanged and bits 7..0 as zero. With the flag clear, all 40 bits are stored.
- R8: A synchronous active-high reset clears every register in both banks, selects the primary bank and drives all read outputs to zero.
- R9: Each external port reads its addressed register on every cycle, including cycles in which it writes that register.
- R10: All five write ports can store to five different registers in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_alt | input | 1 | Bank select: 0 primary, 1 alternate |
| alu_ra_addr | input | 4 | ALU operand A read address |
| alu_rb_addr | input | 4 | ALU operand B read address |
| mul_ra_addr | input | 4 | Multiplier operand A read address |
| mul_rb_addr | input | 4 | Multiplier operand B read address |
| alu_ra_data | output | 40 | ALU operand A read data |
| alu_rb_data | output | 40 | ALU operand B read data |
| mul_ra_data | output | 40 | Multiplier operand A read data |
| mul_rb_data | output | 40 | Multiplier operand B read data |
| alu_we | input | 1 | ALU result write enable |
| alu_waddr | input | 4 | ALU result address |
| alu_wdata | input | 40 | ALU result data |
| alu_wfix | input | 1 | ALU result is fixed-point |
| alu2_we | input | 1 | Second ALU result enable (dual add/subtract) |
| alu2_waddr | input | 4 | Second ALU result address |
| alu2_wdata | input | 40 | Second ALU result data |
| alu2_wfix | input | 1 | Second ALU result is fixed-point |
| mul_we | input | 1 | Multiplier result write enable |
| mul_waddr | input | 4 | Multiplier result address |
| mul_wdata | input | 40 | Multiplier result data |
| mul_wfix | input | 1 | Multiplier result is fixed-point |
| ext0_we | input | 1 | External port 0 write enable |
| ext0_addr | input | 4 | External port 0 register address |
| ext0_wdata | input | 40 | External port 0 write data |
| ext0_wfix | input | 1 | External port 0 data is fixed-point |
| ext0_rdata | output | 40 | External port 0 read data |
| ext1_we | input | 1 | External port 1 write enable |
| ext1_addr | input | 4 | External port 1 register address |
| ext1_wdata | input | 40 | External port 1 write data |
| ext1_wfix | input | 1 | External port 1 data is fixed-point |
| ext1_rdata | output | 40 | External port 1 read data |

## Verification
The assertions assume that enables, addresses, flags and the bank select are known (not X) at every clock edge after reset, and that reset is held for at least one edge before operation starts. The stimulus meets these assumptions. It drives every input to a defined value during reset and changes inputs only a moment after each rising edge. Random addresses are drawn only from the sixteen valid indices. The bank select toggles rarely, so long runs exercise both banks, and the directed cases force collisions between all five writers onto one register.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // write port precedence: lower index wins
  localparam int WP_EXT0 = 0;
  localparam int WP_EXT1 = 1;
  localparam int WP_MUL  = 2;
  localparam int WP_ALU  = 3;
  localparam int WP_ALU2 = 4;
  localparam int NUM_WR  = 5;

  localparam int RP_ALU_A = 0;
  localparam int RP_ALU_B = 1;
  localparam int RP_MUL_A = 2;
  localparam int RP_MUL_B = 3;
  localparam int RP_EXT0  = 4;
  localparam int RP_EXT1  = 5;
  localparam int NUM_RD   = 6;

  typedef enum logic {BANK_PRI = 1'b0, BANK_ALT = 1'b1} bank_e;
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
  import rf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sel_i,
  output bank_e bank_o
);
  always_ff @(posedge clk) begin
    if (rst) bank_o <= BANK_PRI;
    else     bank_o <= bank_e'(sel_i);
  end
endmodule

// File: rtl/rf_wr_format.sv
module rf_wr_format #(
  parameter int DATA_W = 40,
  parameter int FRAC_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              fix_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = data_i;
    if (fix_i) data_o[FRAC_W-1:0] = '0;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int REGS   = 16,
  parameter int N_WR   = NUM_WR,
  parameter int N_RD   = NUM_RD,
  localparam int ADDR_W = $clog2(REGS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  bank_e                        bank_i,
  input  logic [N_WR-1:0]              wr_en,
  input  logic [N_WR-1:0][ADDR_W-1:0]  wr_addr,
  input  logic [N_WR-1:0][DATA_W-1:0]  wr_data,
  input  logic [N_RD-1:0][ADDR_W-1:0]  rd_addr,
  output logic [N_RD-1:0][DATA_W-1:0]  rd_data
);
  logic [REGS-1:0][DATA_W-1:0] mem [2];

  // lowest-precedence port is assigned first so the highest one lands last
  always_ff @(posedge clk) begin
    if (rst) begin
      mem[0] <= '0;
      mem[1] <= '0;
    end else begin
      for (int p = N_WR - 1; p >= 0; p--) begin
        if (wr_en[p]) mem[bank_i][wr_addr[p]] <= wr_data[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      for (int r = 0; r < N_RD; r++) begin
        rd_data[r] <= mem[bank_i][rd_addr[r]];
      end
    end
  end

  // R2: the bank not in use is left untouched
  assert_idle_alt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (bank_i == BANK_PRI) |=> $stable(mem[1]));
  assert_idle_pri_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (bank_i == BANK_ALT) |=> $stable(mem[0]));

  // R5: top-precedence writer always lands
  assert_ext0_wins_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en[WP_EXT0] |=>
      mem[$past(bank_i)][$past(wr_addr[WP_EXT0])] == $past(wr_data[WP_EXT0]));
  // R5: second writer lands unless the first hit the same register
  assert_ext1_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en[WP_EXT1] &&
     !(wr_en[WP_EXT0] && wr_addr[WP_EXT0] == wr_addr[WP_EXT1])) |=>
      mem[$past(bank_i)][$past(wr_addr[WP_EXT1])] == $past(wr_data[WP_EXT1]));
endmodule

// File: rtl/rf_dual_bank.sv
module rf_dual_bank
  import rf_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int REGS   = 16,
  parameter int FRAC_W = 8,
  localparam int ADDR_W = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_alt,
  input  logic [ADDR_W-1:0] alu_ra_addr,
  input  logic [ADDR_W-1:0] alu_rb_addr,
  input  logic [ADDR_W-1:0] mul_ra_addr,
  input  logic [ADDR_W-1:0] mul_rb_addr,
  output logic [DATA_W-1:0] alu_ra_data,
  output logic [DATA_W-1:0] alu_rb_data,
  output logic [DATA_W-1:0] mul_ra_data,
  output logic [DATA_W-1:0] mul_rb_data,
  input  logic              alu_we,
  input  logic [ADDR_W-1:0] alu_waddr,
  input  logic [DATA_W-1:0] alu_wdata,
  input  logic              alu_wfix,
  input  logic              alu2_we,
  input  logic [ADDR_W-1:0] alu2_waddr,
  input  logic [DATA_W-1:0] alu2_wdata,
  input  logic              alu2_wfix,
  input  logic              mul_we,
  input  logic [ADDR_W-1:0] mul_waddr,
  input  logic [DATA_W-1:0] mul_wdata,
  input  logic              mul_wfix,
  input  logic              ext0_we,
  input  logic [ADDR_W-1:0] ext0_addr,
  input  logic [DATA_W-1:0] ext0_wdata,
  input  logic              ext0_wfix,
  output logic [DATA_W-1:0] ext0_rdata,
  input  logic              ext1_we,
  input  logic [ADDR_W-1:0] ext1_addr,
  input  logic [DATA_W-1:0] ext1_wdata,
  input  logic              ext1_wfix,
  output logic [DATA_W-1:0] ext1_rdata
);
  bank_e                              bank_q;
  logic [NUM_WR-1:0]                  wr_en;
  logic [NUM_WR-1:0][ADDR_W-1:0]      wr_addr;
  logic [NUM_WR-1:0][DATA_W-1:0]      wr_raw;
  logic [NUM_WR-1:0]                  wr_fix;
  logic [NUM_WR-1:0][DATA_W-1:0]      wr_fmt;
  logic [NUM_RD-1:0][ADDR_W-1:0]      rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0]      rd_data;

  // index order follows the precedence constants in rf_pkg
  assign wr_en   = {alu2_we,    alu_we,    mul_we,    ext1_we,    ext0_we};
  assign wr_addr = {alu2_waddr, alu_waddr, mul_waddr, ext1_addr,  ext0_addr};
  assign wr_raw  = {alu2_wdata, alu_wdata, mul_wdata, ext1_wdata, ext0_wdata};
  assign wr_fix  = {alu2_wfix,  alu_wfix,  mul_wfix,  ext1_wfix,  ext0_wfix};

  assign rd_addr = {ext1_addr, ext0_addr, mul_rb_addr, mul_ra_addr,
                    alu_rb_addr, alu_ra_addr};

  assign alu_ra_data = rd_data[RP_ALU_A];
  assign alu_rb_data = rd_data[RP_ALU_B];
  assign mul_ra_data = rd_data[RP_MUL_A];
  assign mul_rb_data = rd_data[RP_MUL_B];
  assign ext0_rdata  = rd_data[RP_EXT0];
  assign ext1_rdata  = rd_data[RP_EXT1];

  rf_bank_ctrl u_bank (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (bank_alt),
    .bank_o (bank_q)
  );

  for (genvar p = 0; p < NUM_WR; p++) begin : g_fmt
    rf_wr_format #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_fmt (
      .data_i (wr_raw[p]),
      .fix_i  (wr_fix[p]),
      .data_o (wr_fmt[p])
    );
  end

  rf_storage #(.DATA_W(DATA_W), .REGS(REGS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .bank_i  (bank_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_fmt),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R8: outputs come out of reset at zero
  assert_reset_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alu_ra_data == '0 && alu_rb_data == '0 &&
                    mul_ra_data == '0 && mul_rb_data == '0 &&
                    ext0_rdata == '0 && ext1_rdata == '0));

  // R7: a fixed-point write by the top-precedence port reads back with a clear low byte
  assert_fix_low_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (ext0_we && ext0_wfix) ##1
      (alu_ra_addr == $past(ext0_addr) && $stable(bank_q))
    |=> alu_ra_data[FRAC_W-1:0] == '0);
endmodule

// File: tb/rf_dual_bank_test.sv
module rf_dual_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bank_alt = 1'b0;
  logic [3:0]  alu_ra_addr = '0, alu_rb_addr = '0, mul_ra_addr = '0, mul_rb_addr = '0;
  logic [39:0] alu_ra_data, alu_rb_data, mul_ra_data, mul_rb_data;
  logic        alu_we = 0, alu2_we = 0, mul_we = 0, ext0_we = 0, ext1_we = 0;
  logic [3:0]  alu_waddr = '0, alu2_waddr = '0, mul_waddr = '0, ext0_addr = '0, ext1_addr = '0;
  logic [39:0] alu_wdata = '0, alu2_wdata = '0, mul_wdata = '0, ext0_wdata = '0, ext1_wdata = '0;
  logic        alu_wfix = 0, alu2_wfix = 0, mul_wfix = 0, ext0_wfix = 0, ext1_wfix = 0;
  logic [39:0] ext0_rdata, ext1_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [39:0] m [0:1][0:15];
  bit          bank_m;

  always #5 clk = ~clk;

  rf_dual_bank uut (
    .clk(clk), .rst(rst), .bank_alt(bank_alt),
    .alu_ra_addr(alu_ra_addr), .alu_rb_addr(alu_rb_addr),
    .mul_ra_addr(mul_ra_addr), .mul_rb_addr(mul_rb_addr),
    .alu_ra_data(alu_ra_data), .alu_rb_data(alu_rb_data),
    .mul_ra_data(mul_ra_data), .mul_rb_data(mul_rb_data),
    .alu_we(alu_we), .alu_waddr(alu_waddr), .alu_wdata(alu_wdata), .alu_wfix(alu_wfix),
    .alu2_we(alu2_we), .alu2_waddr(alu2_waddr), .alu2_wdata(alu2_wdata), .alu2_wfix(alu2_wfix),
    .mul_we(mul_we), .mul_waddr(mul_waddr), .mul_wdata(mul_wdata), .mul_wfix(mul_wfix),
    .ext0_we(ext0_we), .ext0_addr(ext0_addr), .ext0_wdata(ext0_wdata), .ext0_wfix(ext0_wfix),
    .ext0_rdata(ext0_rdata),
    .ext1_we(ext1_we), .ext1_addr(ext1_addr), .ext1_wdata(ext1_wdata), .ext1_wfix(ext1_wfix),
    .ext1_rdata(ext1_rdata)
  );

  function automatic logic [39:0] fmt(input logic [39:0] d, input logic fix);
    return fix ? {d[39:8], 8'h00} : d;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alu_we = 0; alu2_we = 0; mul_we = 0; ext0_we = 0; ext1_we = 0;
    alu_wfix = 0; alu2_wfix = 0; mul_wfix = 0; ext0_wfix = 0; ext1_wfix = 0;
  endtask

  // one clock: predict reads from pre-edge model, apply writes by precedence, then compare
  task automatic step(input string req);
    logic [39:0] e [6];
    e[0] = m[bank_m][alu_ra_addr];
    e[1] = m[bank_m][alu_rb_addr];
    e[2] = m[bank_m][mul_ra_addr];
    e[3] = m[bank_m][mul_rb_addr];
    e[4] = m[bank_m][ext0_addr];
    e[5] = m[bank_m][ext1_addr];
    if (alu2_we) m[bank_m][alu2_waddr] = fmt(alu2_wdata, alu2_wfix);
    if (alu_we)  m[bank_m][alu_waddr]  = fmt(alu_wdata,  alu_wfix);
    if (mul_we)  m[bank_m][mul_waddr]  = fmt(mul_wdata,  mul_wfix);
    if (ext1_we) m[bank_m][ext1_addr]  = fmt(ext1_wdata, ext1_wfix);
    if (ext0_we) m[bank_m][ext0_addr]  = fmt(ext0_wdata, ext0_wfix);
    bank_m = bank_alt;
    @(posedge clk);
    #1;
    check(req, "alu_ra", alu_ra_data, e[0]);
    check(req, "alu_rb", alu_rb_data, e[1]);
    check(req, "mul_ra", mul_ra_data, e[2]);
    check(req, "mul_rb", mul_rb_data, e[3]);
    check(req, "ext0",   ext0_rdata,  e[4]);
    check(req, "ext1",   ext1_rdata,  e[5]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [39:0] va, vb, d0, d1, d2, d3, d4;
    void'($urandom(32'h1234_5EED));
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 16; a++) m[b][a] = '0;
    bank_m = 0;

    // R8: reset state
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R8", "alu_ra after reset", alu_ra_data, '0);
    check("R8", "ext1 after reset", ext1_rdata, '0);
    for (int a = 0; a < 16; a++) begin
      ext0_addr = 4'(a); ext1_addr = 4'(15 - a);
      step("R8");
    end
    bank_alt = 1; step("R8");
    for (int a = 0; a < 16; a++) begin
      ext0_addr = 4'(a); alu_ra_addr = 4'(a);
      step("R8");
    end
    bank_alt = 0; step("R2");

    // R7: fixed-point write clears low byte
    ext0_we = 1; ext0_addr = 5; ext0_wdata = 40'hAB_CDEF_1234; ext0_wfix = 1;
    step("R7");
    idle(); alu_ra_addr = 5; step("R7");
    check("R7", "fixed word", alu_ra_data, 40'hAB_CDEF_1200);
    mul_we = 1; mul_waddr = 6; mul_wdata = 40'h11_2233_4455; step("R7");
    idle(); mul_rb_addr = 6; step("R7");
    check("R7", "full word", mul_rb_data, 40'h11_2233_4455);

    // R5: all five writers collide on register 9
    d0 = 40'h00_0000_00A0; d1 = 40'h00_0000_00B1; d2 = 40'h00_0000_00C2;
    d3 = 40'h00_0000_00D3; d4 = 40'h00_0000_00E4;
    ext0_we = 1; ext0_addr = 9; ext0_wdata = d0;
    ext1_we = 1; ext1_addr = 9; ext1_wdata = d1;
    mul_we = 1;  mul_waddr = 9; mul_wdata = d2;
    alu_we = 1;  alu_waddr = 9; alu_wdata = d3;
    alu2_we = 1; alu2_waddr = 9; alu2_wdata = d4;
    step("R5");
    idle(); mul_ra_addr = 9; step("R5");
    check("R5", "ext0 beats all", mul_ra_data, d0);
    ext1_we = 1; mul_we = 1; alu_we = 1; alu2_we = 1; step("R5");
    idle(); step("R5");
    check("R5", "ext1 beats compute", mul_ra_data, d1);
    mul_we = 1; alu_we = 1; alu2_we = 1; step("R5");
    idle(); step("R5");
    check("R5", "mul beats alu", mul_ra_data, d2);
    alu_we = 1; alu2_we = 1; step("R5");
    idle(); step("R5");
    check("R5", "alu beats alu2", mul_ra_data, d3);

    // R6: second ALU port needs its strobe
    alu2_we = 0; alu2_waddr = 9; alu2_wdata = 40'hFF_FFFF_FFFF; step("R6");
    idle(); step("R6");
    check("R6", "alu2 disabled ignored", mul_ra_data, d3);
    alu2_we = 1; step("R6");
    idle(); step("R6");
    check("R6", "alu2 enabled stores", mul_ra_data, 40'hFF_FFFF_FFFF);

    // R4 / R9: same-cycle read returns old, next cycle new
    ext1_we = 1; ext1_addr = 2; ext1_wdata = 40'h55_AA55_AA55; step("R9");
    check("R9", "ext1 old during write", ext1_rdata, '0);
    idle(); step("R4");
    check("R4", "ext1 new after write", ext1_rdata, 40'h55_AA55_AA55);

    // R2 / R3: bank switch timing and independence
    va = 40'h01_0101_0101; vb = 40'h02_0202_0202;
    bank_alt = 1; ext0_we = 1; ext0_addr = 3; ext0_wdata = va; step("R2");
    ext0_wdata = vb; step("R3");
    idle(); alu_rb_addr = 3; step("R3");
    check("R3", "alternate copy", alu_rb_data, vb);
    bank_alt = 0; step("R2");
    step("R2");
    check("R2", "primary copy after switch", alu_rb_data, va);

    // R1 / R10: random traffic across both banks
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(15) == 0) bank_alt = ~bank_alt;
      alu_ra_addr = 4'($urandom); alu_rb_addr = 4'($urandom);
      mul_ra_addr = 4'($urandom); mul_rb_addr = 4'($urandom);
      ext0_addr = 4'($urandom); ext1_addr = 4'($urandom);
      alu_waddr = 4'($urandom); alu2_waddr = 4'($urandom); mul_waddr = 4'($urandom);
      alu_we = 1'($urandom); alu2_we = 1'($urandom); mul_we = 1'($urandom);
      ext0_we = 1'($urandom); ext1_we = 1'($urandom);
      alu_wfix = ($urandom_range(3) == 0); alu2_wfix = ($urandom_range(3) == 0);
      mul_wfix = ($urandom_range(3) == 0); ext0_wfix = ($urandom_range(3) == 0);
      ext1_wfix = ($urandom_range(3) == 0);
      alu_wdata = {8'($urandom), $urandom}; alu2_wdata = {8'($urandom), $urandom};
      mul_wdata = {8'($urandom), $urandom}; ext0_wdata = {8'($urandom), $urandom};
      ext1_wdata = {8'($urandom), $urandom};
      step((i % 2 == 0) ? "R1" : "R10");
    end
    idle(); step("R1");

    done = 1;
    finish_run();
  end
endmodule